// File: doc/BRIEF.md
# Prescaled Cascadable Event Counter

This block is an up/down event counter of configurable width (32 bits by default). It runs on a single clock. The event it counts is one of three things: every clock cycle (the internal timebase), rising edges of an external event pin, or rising edges of the gate pin. A small prescaler can sit between the chosen event and the main counter, dividing by 2 or by 8. The prescaler cannot be read, so a count taken through it leaves out the events since its last rollover. The prescaler may only be used with an externally supplied event. Asking for it together with the internal timebase, or asking for an encoding that does not exist, is refused: a sticky error flag is set and the counter stays disarmed.

The arm, gate, direction and external event inputs are asynchronous. Each one passes through a two-flop synchronizer before the counter uses it. Edges are then found one cycle later by comparing the synchronized value with its previous value. The configuration inputs are taken when the synchronized arm input rises, and at that moment the count is cleared.

When the count wraps, the block gives a one-cycle terminal-count pulse and toggles an internal output. Wiring the pulse of one instance to the gate of a second instance whose event is set to gate edges chains the two into a counter of twice the width.

Top module: `prescaled_event_counter`

## Requirements
- R1: After reset, `count` is 0 and `tc`, `int_out` and `cfg_err` are 0.
- R2: With `src_sel`=00 (internal timebase), the counter steps once per clock while armed. The synchronized rising edge of `arm` clears the count. If `arm` is held high for T cycles, the final count is T-1. After `arm` falls, the count holds its value.
- R3: With `src_sel`=01, each rising edge of `ext_src` seen while armed is one event.
- R4: `up_dn`=1 counts up and `up_dn`=0 counts down. Counting down from 0 gives all-ones.
- R5: `tc` is high for exactly one cycle each time the count wraps, in either direction. Going up, the wrap is all-ones to 0; going down, it is 0 to all-ones. `int_out` toggles with every `tc` pulse.
- R6: `presc_sel`=01 divides events by 2. The count steps on every second event, and a pending odd event does not show in `count`.
- R7: `presc_sel`=10 divides events by 8. Fewer than 8 events leave `count` unchanged.
- R8: An arm is illegal when `src_sel`=00 with a nonzero `presc_sel`, when `presc_sel`=11, or when `src_sel`=11. An illegal arm sets `cfg_err`, which stays set until reset. It leaves the counter disarmed, so `count` keeps its prior value. A later legal arm still works.
- R9: With `gate_en`=1 and `src_sel` other than 10, events count only while the synchronized `gate` is high.
- R10: With `src_sel`=10, each rising edge of `gate` is one event. When the `tc` of one instance feeds this gate, the second instance counts the wraps of the first, and the two counts together form the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock (internal timebase) |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Event select: 00 internal, 01 external pin, 10 gate edges, 11 illegal |
| presc_sel | input | 2 | Prescale: 00 bypass, 01 divide by 2, 10 divide by 8, 11 illegal |
| gate_en | input | 1 | When 1, the gate level enables counting |
| ext_src | input | 1 | Asynchronous external event input |
| gate | input | 1 | Asynchronous gate input |
| up_dn | input | 1 | Asynchronous direction: 1 up, 0 down |
| arm | input | 1 | Asynchronous arm level; the rising edge arms, the falling edge disarms |
| count | output | WIDTH | Current count |
| tc | output | 1 | One-cycle terminal-count pulse |
| int_out | output | 1 | Toggles on every terminal count |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The bench counts down out of zero. An off-by-one wrap comparison would then give no `tc` pulse, or a count that is one step off. Events are fed through both prescale settings in counts that leave a remainder, and a design that rolled over one event early or late ends with the wrong quotient. Illegal arms are tried after a nonzero count, so a design that cleared, armed or reset its error flag anyway shows a changed count or a cleared flag. A 4-bit pair is chained through `tc` into the gate. If the design stretched the pulse, or lost it in the synchronizer, the high half would be wrong.

// File: rtl/prescaled_event_counter.sv
module prescaled_event_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [1:0]       presc_sel,
  input  logic             gate_en,
  input  logic             ext_src,
  input  logic             gate,
  input  logic             up_dn,
  input  logic             arm,
  output logic [WIDTH-1:0] count,
  output logic             tc,
  output logic             int_out,
  output logic             cfg_err
);
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ALL1 = '1;

  logic [2:0] arm_sr, gate_sr, ext_sr;
  logic [1:0] dir_sr;
  logic [1:0] src_r, psel_r;
  logic       gen_r, armed;
  logic [2:0] pres;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm_sr <= '0; gate_sr <= '0; ext_sr <= '0; dir_sr <= '0;
    end else begin
      arm_sr  <= {arm_sr[1:0], arm};
      gate_sr <= {gate_sr[1:0], gate};
      ext_sr  <= {ext_sr[1:0], ext_src};
      dir_sr  <= {dir_sr[0], up_dn};
    end

  wire arm_rise  = arm_sr[1] & ~arm_sr[2];
  wire arm_fall  = ~arm_sr[1] & arm_sr[2];
  wire gate_rise = gate_sr[1] & ~gate_sr[2];
  wire ext_rise  = ext_sr[1] & ~ext_sr[2];
  wire up        = dir_sr[1];

  wire bad_cfg = (src_sel == 2'b11) || (presc_sel == 2'b11) ||
                 (src_sel == 2'b00 && presc_sel != 2'b00);

  logic raw_evt;
  always_comb
    case (src_r)
      2'b00:   raw_evt = 1'b1;
      2'b01:   raw_evt = ext_rise;
      2'b10:   raw_evt = gate_rise;
      default: raw_evt = 1'b0;
    endcase

  wire       lvl_ok  = (src_r == 2'b10) || !gen_r || gate_sr[1];
  wire       evt     = armed & raw_evt & lvl_ok;
  wire [2:0] pre_max = (psel_r == 2'b01) ? 3'd1 : 3'd7;
  wire       step    = evt & ((psel_r == 2'b00) || (pres == pre_max));
  wire       wrap    = up ? (count == ALL1) : (count == ZERO);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0; tc <= 1'b0; int_out <= 1'b0; cfg_err <= 1'b0;
      armed <= 1'b0; pres <= '0; src_r <= '0; psel_r <= '0; gen_r <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (arm_rise) begin
        if (bad_cfg) begin
          cfg_err <= 1'b1;
          armed   <= 1'b0;
          psel_r  <= 2'b00;
        end else begin
          armed  <= 1'b1;
          count  <= '0;
          pres   <= '0;
          src_r  <= src_sel;
          psel_r <= presc_sel;
          gen_r  <= gate_en;
        end
      end else if (arm_fall) begin
        armed <= 1'b0;
      end else if (evt) begin
        if (psel_r != 2'b00) pres <= (pres == pre_max) ? 3'd0 : pres + 3'd1;
        if (step) begin
          count   <= up ? count + ONE : count - ONE;
          tc      <= wrap;
          int_out <= int_out ^ wrap;
        end
      end
    end

  // R5
  tc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);
  // R5
  tc_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> ((count == ZERO && $past(count) == ALL1) ||
            (count == ALL1 && $past(count) == ZERO)));
  // R5
  int_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out != $past(int_out)) |-> tc);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R8
  bad_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_rise && bad_cfg) |=> (!armed && cfg_err));
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_rise) |=> $stable(count));
endmodule

// File: tb/tb_prescaled_event_counter.sv
`timescale 1ns/1ps
module tb_prescaled_event_counter;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [1:0] src_sel = 0, presc_sel = 0;
  logic gate_en = 0, ext_src = 0, gate = 0, up_dn = 1, arm = 0;
  logic [31:0] count;
  logic tc, int_out, cfg_err;

  prescaled_event_counter #(.WIDTH(32)) dut (
    .clk, .rst_n, .src_sel, .presc_sel, .gate_en, .ext_src, .gate, .up_dn,
    .arm, .count, .tc, .int_out, .cfg_err);

  logic a_arm = 0, b_arm = 0;
  logic [3:0] a_cnt, b_cnt;
  logic a_tc, b_tc, a_io, b_io, a_err, b_err;

  prescaled_event_counter #(.WIDTH(4)) ca (
    .clk, .rst_n, .src_sel(2'b00), .presc_sel(2'b00), .gate_en(1'b0),
    .ext_src(1'b0), .gate(1'b0), .up_dn(1'b1), .arm(a_arm),
    .count(a_cnt), .tc(a_tc), .int_out(a_io), .cfg_err(a_err));
  prescaled_event_counter #(.WIDTH(4)) cb (
    .clk, .rst_n, .src_sel(2'b10), .presc_sel(2'b00), .gate_en(1'b0),
    .ext_src(1'b0), .gate(a_tc), .up_dn(1'b1), .arm(b_arm),
    .count(b_cnt), .tc(b_tc), .int_out(b_io), .cfg_err(b_err));

  int checks = 0, fails = 0, dut_tcs = 0, a_tcs = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (tc) dut_tcs++;
    if (a_tc) a_tcs++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_for(input int t);
    arm = 1; cyc(t); arm = 0; cyc(5);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_src = 1; cyc(2); ext_src = 0; cyc(2);
    end
  endtask

  task automatic t_reset;
    check(count == 0, "R1 count", count, 0);
    check(tc == 0, "R1 tc", tc, 0);
    check(int_out == 0, "R1 int_out", int_out, 0);
    check(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_internal_up;
    src_sel = 0; presc_sel = 0; up_dn = 1; cyc(4);
    arm_for(10);
    check(count == 9, "R2 internal count", count, 9);
    cyc(6);
    check(count == 9, "R2 hold after disarm", count, 9);
  endtask

  task automatic t_down;
    int tc0; logic io0;
    tc0 = dut_tcs; io0 = int_out;
    up_dn = 0; cyc(4);
    arm_for(3);
    check(count == 32'hFFFF_FFFE, "R4 down wrap", count, 32'hFFFF_FFFE);
    check(dut_tcs - tc0 == 1, "R5 tc down", dut_tcs - tc0, 1);
    check(int_out == !io0, "R5 int_out toggle", int_out, !io0);
    up_dn = 1; cyc(4);
  endtask

  task automatic t_ext(input logic [1:0] ps, input int n, input int exp, input string req);
    src_sel = 1; presc_sel = ps; cyc(3);
    arm = 1; cyc(5);
    pulses(n);
    cyc(4); arm = 0; cyc(5);
    check(count == exp, req, count, exp);
  endtask

  task automatic t_gate_level;
    src_sel = 0; presc_sel = 0; gate_en = 1; gate = 0; cyc(3);
    arm = 1; cyc(6);
    gate = 1; cyc(5); gate = 0; cyc(6);
    arm = 0; cyc(5);
    check(count == 5, "R9 gate level", count, 5);
    gate_en = 0;
  endtask

  task automatic t_bad;
    src_sel = 0; presc_sel = 1; cyc(3);
    arm = 1; cyc(8);
    check(cfg_err == 1, "R8 error set (int+div2)", cfg_err, 1);
    check(count == 5, "R8 not armed", count, 5);
    arm = 0; cyc(5);
    src_sel = 1; presc_sel = 3; cyc(3);
    arm = 1; ext_src = 1; cyc(3); ext_src = 0; cyc(3); arm = 0; cyc(5);
    check(count == 5, "R8 psel 11 not armed", count, 5);
    src_sel = 3; presc_sel = 0; cyc(3);
    arm_for(6);
    check(count == 5, "R8 src 11 not armed", count, 5);
    check(cfg_err == 1, "R8 sticky", cfg_err, 1);
    src_sel = 0; presc_sel = 0; cyc(3);
    arm_for(4);
    check(count == 3, "R8 later legal arm", count, 3);
    check(cfg_err == 1, "R8 sticky after legal arm", cfg_err, 1);
  endtask

  task automatic t_cascade;
    int t0; t0 = a_tcs;
    b_arm = 1; cyc(5);
    a_arm = 1; cyc(40); a_arm = 0; cyc(8);
    b_arm = 0; cyc(5);
    check(a_cnt == 7, "R10 low half", a_cnt, 7);
    check(b_cnt == 2, "R10 high half", b_cnt, 2);
    check(a_tcs - t0 == 2, "R5 tc up wraps", a_tcs - t0, 2);
    check({b_cnt, a_cnt} == 39, "R10 combined", {b_cnt, a_cnt}, 39);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_reset();
    t_internal_up();
    t_down();
    t_ext(2'b00, 5, 5, "R3 external edges");
    t_ext(2'b01, 5, 2, "R6 divide by 2");
    t_ext(2'b10, 20, 2, "R7 divide by 8");
    t_ext(2'b10, 7, 0, "R7 remainder hidden");
    t_gate_level();
    t_bad();
    t_cascade();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule